// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a byte-wide NOR flash. It samples the three active-low bus strobes (chip select, read strobe, write strobe) on the system clock. It picks out one write event for each strobe assertion and runs the captured address and data through a decoder for multi-cycle command sequences. The decoder steers the part between array reading, identification read-back, byte programming and erasing. The storage array lives outside the block: during normal reads the block forwards the array's data byte to the data output. The program and erase algorithms are stood in for by a timed busy phase. A fault input can end that phase in an error state, which models a timeout.

A host unlocks the part with two fixed writes and then issues a command byte. Identification mode stays active until the host sends the reset byte. A program or erase that has begun cannot be interrupted. A wrong write anywhere inside a sequence drops the part back to array reading.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write is taken only in a cycle where `ce_n`=0, `we_n`=0 and `oe_n`=1. A cycle with `oe_n`=0, `ce_n`=1 or `we_n`=1 changes no state.
- R2: Each continuous stretch of qualified write cycles counts as exactly one write. Its address and data are taken from the first cycle of the stretch, and the state changes at that clock edge.
- R3: Reset leaves the block in array-read mode with `busy`=0 and `err`=0. In array-read mode and during an unfinished sequence, `dout` equals `array_q`. `dout` is 00h whenever `ce_n` or `oe_n` is 1.
- R4: Sequences compare `addr[10:0]`. Unlock is AAh at 555h followed by 55h at 2AAh. The next write is the command: 90h at 555h enters identification mode, A0h at 555h arms a program, and 80h at 555h continues an erase. An erase continues with AAh at 555h, then 55h at 2AAh, then either 10h at 555h (whole chip) or 30h at any address (one sector).
- R5: Inside a sequence, a write whose address or data does not fit the next expected step returns the block to array-read mode.
- R6: A write of F0h at any address in array-read mode, inside a sequence, or in identification mode returns the block to array-read mode.
- R7: In identification mode, every write other than F0h is ignored. Reads decode `addr[1:0]`: 0 gives 01h, 1 gives 20h, 2 gives 01h if bit `addr[16:14]` of `sect_prot` is set and 00h otherwise, and 3 gives 00h.
- R8: After A0h, the next write (the program byte) starts the busy phase, and so does the last erase write. `busy` is then 1 for exactly BUSY_CYCLES cycles and `dout` reads 00h. Afterwards the block is in array-read mode.
- R9: During the busy phase every write, F0h included, is ignored, and the length of the phase does not change.
- R10: `fail_inject`=1 in a busy cycle moves the block to the error state on that edge. In the error state `err`=1, `busy`=0 and `dout` reads 20h. Only a write of F0h leaves the error state, back to array-read mode. `busy` and `err` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data |
| array_q | input | 8 | Data byte from the storage array |
| sect_prot | input | 8 | Protection bit per sector |
| fail_inject | input | 1 | Forces the busy phase into the error state |
| dout | output | 8 | Read data |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Operation ended in error |

## Verification
The bench holds the write strobe low for two cycles right after an A0h command. A design that counts a held strobe twice would treat the second cycle as the program byte and go busy early. It also slips a write that has the read strobe low and junk data into the middle of an unlock. If that write were accepted, the sequence would be lost and identification mode would never be reached. A reset byte is sent partway through the busy phase, and the bench checks that the phase still lasts exactly BUSY_CYCLES cycles. The error state is checked for leaking back to array reading on junk writes. Random traffic weighted toward valid steps reaches every sequence state, and a bench model predicts each flag and each read byte.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_ERS1, S_ERS2, S_ERS3, S_PGM, S_AUTO, S_BUSY, S_ERR
  } fcc_state_e;

  localparam logic [7:0] C_UNLK_A = 8'hAA;
  localparam logic [7:0] C_UNLK_B = 8'h55;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERASE  = 8'h80;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [10:0] A_FIRST  = 11'h555;
  localparam logic [10:0] A_SECOND = 11'h2AA;
  localparam logic [7:0] ID_MFR   = 8'h01;
  localparam logic [7:0] ID_DEV   = 8'h20;
  localparam logic [7:0] ERR_BYTE = 8'h20;

  // true when a write matches one expected sequence step
  function automatic logic step_hit(logic [10:0] a, logic [7:0] d,
                                    logic [10:0] ea, logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // identification byte for a read selector and the sector's protect bit
  function automatic logic [7:0] ident_byte(logic [1:0] sel, logic prot);
    case (sel)
      2'd0:    return ID_MFR;
      2'd1:    return ID_DEV;
      2'd2:    return {7'd0, prot};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/fcc_wr_qual.sv
module fcc_wr_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic fire
);
  logic qual, qual_q;
  assign qual = !ce_n && !we_n && oe_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual;
  assign fire = qual && !qual_q;
endmodule

// File: rtl/fcc_busy_timer.sv
module fcc_busy_timer #(
  parameter int BUSY_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  assign done = (cnt == '0);
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import fcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic [10:0] wa,
  input  logic [7:0]  wd,
  input  logic        op_done,
  input  logic        fail_inject,
  output fcc_state_e  st,
  output logic        op_start
);
  fcc_state_e nxt;

  always_comb begin
    nxt = st;
    if (st == S_BUSY) begin
      if (fail_inject)  nxt = S_ERR;
      else if (op_done) nxt = S_READ;
    end else if (st == S_ERR) begin
      if (fire && wd == C_RESET) nxt = S_READ;
    end else if (fire) begin
      if (wd == C_RESET) nxt = S_READ;
      else begin
        nxt = S_READ;
        case (st)
          S_READ: if (step_hit(wa, wd, A_FIRST,  C_UNLK_A)) nxt = S_UNL1;
          S_UNL1: if (step_hit(wa, wd, A_SECOND, C_UNLK_B)) nxt = S_UNL2;
          S_UNL2: begin
            if      (step_hit(wa, wd, A_FIRST, C_IDENT)) nxt = S_AUTO;
            else if (step_hit(wa, wd, A_FIRST, C_PROG))  nxt = S_PGM;
            else if (step_hit(wa, wd, A_FIRST, C_ERASE)) nxt = S_ERS1;
          end
          S_ERS1: if (step_hit(wa, wd, A_FIRST,  C_UNLK_A)) nxt = S_ERS2;
          S_ERS2: if (step_hit(wa, wd, A_SECOND, C_UNLK_B)) nxt = S_ERS3;
          S_ERS3: if (step_hit(wa, wd, A_FIRST, C_CHIP) || wd == C_SECT) nxt = S_BUSY;
          S_PGM:  nxt = S_BUSY;
          S_AUTO: nxt = S_AUTO;
          default: nxt = S_READ;
        endcase
      end
    end
  end

  assign op_start = (st != S_BUSY) && (nxt == S_BUSY);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_READ;
    else        st <= nxt;
endmodule

// File: rtl/fcc_rd_mux.sv
module fcc_rd_mux
  import fcc_pkg::*;
#(
  parameter int SECT_BITS = 3
) (
  input  logic                   rd_en,
  input  fcc_state_e             st,
  input  logic [1:0]             sel,
  input  logic [SECT_BITS-1:0]   sect,
  input  logic [(1<<SECT_BITS)-1:0] prot,
  input  logic [7:0]             array_q,
  output logic [7:0]             dout
);
  always_comb begin
    dout = 8'h00;
    if (rd_en) begin
      case (st)
        S_AUTO:  dout = ident_byte(sel, prot[sect]);
        S_BUSY:  dout = 8'h00;
        S_ERR:   dout = ERR_BYTE;
        default: dout = array_q;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SECT_BITS   = 3,
  parameter int BUSY_CYCLES = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_n,
  input  logic                      oe_n,
  input  logic                      we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                din,
  input  logic [7:0]                array_q,
  input  logic [(1<<SECT_BITS)-1:0] sect_prot,
  input  logic                      fail_inject,
  output logic [7:0]                dout,
  output logic                      busy,
  output logic                      err
);
  localparam int CMD_AW = 11;

  logic       wr_fire, op_start, op_done, st_auto;
  logic [7:0] wr_data;
  fcc_state_e st;

  assign wr_data = din;

  fcc_wr_qual u_qual (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .fire(wr_fire)
  );

  fcc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fire(wr_fire), .wa(addr[CMD_AW-1:0]), .wd(wr_data),
    .op_done(op_done), .fail_inject(fail_inject), .st(st), .op_start(op_start)
  );

  fcc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(op_start), .done(op_done)
  );

  fcc_rd_mux #(.SECT_BITS(SECT_BITS)) u_rd (
    .rd_en(!ce_n && !oe_n), .st(st), .sel(addr[1:0]),
    .sect(addr[ADDR_W-1 -: SECT_BITS]), .prot(sect_prot),
    .array_q(array_q), .dout(dout)
  );

  assign busy    = (st == S_BUSY);
  assign err     = (st == S_ERR);
  assign st_auto = (st == S_AUTO);
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter int BUSY_CYCLES = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       wr_fire,
  input logic [7:0] wr_data,
  input logic       st_auto,
  input logic       busy,
  input logic       err,
  input logic [7:0] dout
);
  localparam int CW = $clog2(BUSY_CYCLES + 2);
  logic [CW-1:0] bz_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bz_cnt <= '0;
    else if (busy) bz_cnt <= bz_cnt + 1'b1;
    else           bz_cnt <= '0;

  p_fire_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
  p_dout_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> dout == 8'h00);
  p_auto_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_auto && !(wr_fire && wr_data == 8'hF0)) |=> st_auto);
  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bz_cnt < CW'(BUSY_CYCLES));
  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !err) |-> $past(bz_cnt) == CW'(BUSY_CYCLES - 1));
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && err));
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(wr_fire && wr_data == 8'hF0)) |=> err);
endmodule

bind flash_cmd_ctrl fcc_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wr_fire(wr_fire),
  .wr_data(wr_data), .st_auto(st_auto), .busy(busy), .err(err), .dout(dout)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int BZ = 12;
  localparam int M_RD = 0, M_U1 = 1, M_U2 = 2, M_E1 = 3, M_E2 = 4, M_E3 = 5,
                 M_PG = 6, M_AS = 7, M_BZ = 8, M_ER = 9;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, fail_inject = 0;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0, array_q, sect_prot = 8'b1010_0110, dout;
  logic busy, err;
  int nchk = 0, nfail = 0, m = M_RD;
  bit done_rep = 0;

  assign array_q = addr[7:0] ^ 8'hC3;
  always #4 clk = ~clk;

  flash_cmd_ctrl #(.BUSY_CYCLES(BZ)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .array_q(array_q), .sect_prot(sect_prot), .fail_inject(fail_inject),
    .dout(dout), .busy(busy), .err(err)
  );

  function automatic int model_step(int s, logic [16:0] a, logic [7:0] d);
    bit f = (a[10:0] == 11'h555), g = (a[10:0] == 11'h2AA);
    if (s == M_BZ) return s;
    if (s == M_ER) return (d == 8'hF0) ? M_RD : M_ER;
    if (d == 8'hF0) return M_RD;
    case (s)
      M_RD: return (f && d == 8'hAA) ? M_U1 : M_RD;
      M_U1: return (g && d == 8'h55) ? M_U2 : M_RD;
      M_U2: return !f ? M_RD : (d == 8'h90) ? M_AS : (d == 8'hA0) ? M_PG :
                   (d == 8'h80) ? M_E1 : M_RD;
      M_E1: return (f && d == 8'hAA) ? M_E2 : M_RD;
      M_E2: return (g && d == 8'h55) ? M_E3 : M_RD;
      M_E3: return ((f && d == 8'h10) || d == 8'h30) ? M_BZ : M_RD;
      M_PG: return M_BZ;
      default: return M_AS;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(int s, logic [16:0] a);
    if (s == M_AS) begin
      if (a[1:0] == 2'd0) return 8'h01;
      if (a[1:0] == 2'd1) return 8'h20;
      if (a[1:0] == 2'd2) return sect_prot[a[16:14]] ? 8'h01 : 8'h00;
      return 8'h00;
    end
    if (s == M_BZ) return 8'h00;
    if (s == M_ER) return 8'h20;
    return a[7:0] ^ 8'hC3;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done_rep) begin
      done_rep = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic wr(logic [16:0] a, logic [7:0] d, int hold = 1);
    @(negedge clk);
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    repeat (hold) @(negedge clk);
    ce_n = 1; we_n = 1;
    m = model_step(m, a, d);
  endtask

  task automatic rd_chk(string req, logic [16:0] a);
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    #2 chk(req, dout, exp_read(m, a));
    ce_n = 1; oe_n = 1;
  endtask

  task automatic flags_chk(string req);
    chk(req, {7'd0, busy}, {7'd0, m == M_BZ});
    chk(req, {7'd0, err},  {7'd0, m == M_ER});
  endtask

  // runs one busy phase; optional error injection or reset write at cycle k
  task automatic busy_run(bit inj, bit poke, int k);
    for (int i = 0; i < BZ; i++) begin
      chk("R8 busy", {7'd0, busy}, 8'd1);
      if (poke && i == k + 1) begin ce_n = 1; we_n = 1; end
      if (poke && i == k) begin ce_n = 0; we_n = 0; oe_n = 1; din = 8'hF0; end
      if (!poke && !inj && i == 1) begin
        ce_n = 0; oe_n = 0; #1 chk("R8 dout", dout, 8'h00); ce_n = 1; oe_n = 1;
      end
      if (inj && i == k) fail_inject = 1;
      @(negedge clk);
      if (inj && i == k) begin
        fail_inject = 0; m = M_ER;
        chk("R10 err", {7'd0, err}, 8'd1);
        chk("R10 busy", {7'd0, busy}, 8'd0);
        return;
      end
    end
    ce_n = 1; we_n = 1;
    m = M_RD;
    chk("R8 end", {7'd0, busy}, 8'd0);
  endtask

  task automatic unlock();
    wr(17'h00555, 8'hAA);
    wr(17'h002AA, 8'h55);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    flags_chk("R3");
    #1 chk("R3 idle", dout, 8'h00);
    rd_chk("R3 read", 17'h1_2345);
    // R4/R7 identification
    unlock(); wr(17'h00555, 8'h90);
    for (int s = 0; s < 8; s++) rd_chk("R7 prot", {s[2:0], 12'h000, 2'd2});
    rd_chk("R7 mfr", 17'h00000);
    rd_chk("R7 dev", 17'h04001);
    rd_chk("R7 rsv", 17'h00003);
    wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h55);
    rd_chk("R7 sticky", 17'h00001);
    wr(17'h1_7777, 8'hF0);
    rd_chk("R6 exit", 17'h00001);
    // R1 inhibited write inside unlock
    wr(17'h00555, 8'hAA);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = 17'h0_0123; din = 8'h00;
    @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
    wr(17'h002AA, 8'h55); wr(17'h00555, 8'h90);
    rd_chk("R1 inhibit", 17'h00001);
    wr(17'h00000, 8'hF0);
    // R2 held strobe counted once, then program with ignored reset (R9)
    unlock(); wr(17'h00555, 8'hA0, 2);
    flags_chk("R2 held");
    wr(17'h0_1000, 8'h3C);
    busy_run(0, 1, 3);
    rd_chk("R9 after", 17'h00000);
    // R5 malformed command
    unlock(); wr(17'h00555, 8'h77);
    wr(17'h00555, 8'h90);
    rd_chk("R5", 17'h00000);
    // R6 reset mid erase sequence
    unlock(); wr(17'h00555, 8'h80); wr(17'h0_4ABC, 8'hF0);
    wr(17'h00555, 8'h90);
    rd_chk("R6 mid", 17'h00001);
    // R10 chip erase with fault
    unlock(); wr(17'h00555, 8'h80); unlock(); wr(17'h00555, 8'h10);
    busy_run(1, 0, 4);
    rd_chk("R10 dout", 17'h00000);
    wr(17'h00555, 8'hAA); flags_chk("R10 hold");
    wr(17'h00555, 8'hF0); flags_chk("R10 exit");
    // R8 sector erase, full length
    unlock(); wr(17'h00555, 8'h80); unlock(); wr(17'h1_C000, 8'h30);
    busy_run(0, 0, 0);
    // random traffic
    for (int it = 0; it < 300; it++) begin
      logic [16:0] a;
      logic [7:0] d;
      int r = $urandom % 10;
      a = 17'($urandom); d = 8'($urandom);
      if (r < 6) begin
        case (m)
          M_RD, M_E1: begin a = 17'h00555; d = 8'hAA; end
          M_U1, M_E2: begin a = 17'h002AA; d = 8'h55; end
          M_U2: begin
            a = 17'h00555;
            d = ($urandom % 3 == 0) ? 8'h90 : ($urandom % 2 == 0) ? 8'hA0 : 8'h80;
          end
          M_E3: begin a = 17'h00555; d = ($urandom % 2 == 0) ? 8'h10 : 8'h30; end
          M_PG: ;
          default: d = ($urandom % 3 == 0) ? 8'hF0 : d;
        endcase
      end else if (r == 6) d = 8'hF0;
      wr(a, d);
      if (m == M_BZ) busy_run($urandom % 4 == 0, 0, $urandom_range(0, BZ - 2));
      flags_chk("R10 flags");
      rd_chk((m == M_AS) ? "R7 rand" : "R4 rand", 17'($urandom));
    end
    report();
  end
endmodule